// File: doc/BRIEF.md
# Camera Trigger and Strobe Sequencer

This block turns a trigger into a timed exposure for an image sensor. The trigger comes either from an external pin or from a bit that software sets. After a programmable delay the block opens an integration window, closes it, and then gives a single-cycle pulse that tells the readout logic to start. Alongside the window it drives a strobe output for an illumination source. The strobe can be lit a programmed time before integration starts, or a programmed time after it starts. It can also be limited to a programmed width, and it always goes dark when integration ends.

Integration length has three sources: a register value, the time the trigger is held active, or an end pulse from the sensor side. The sequencer runs once per trigger edge in one-shot mode. In retriggerable mode it repeats frames, with a programmable gap between them, for as long as the trigger stays active. All time registers count in steps. Each kind of step is a parameterised number of clock cycles, so a register value `v` with step `S` gives `v*S` cycles. The pin and the software bit are both clocked through a two-stage synchronizer before use.

Top module: `camera_trig_seq`

## Requirements
- R1: `cfg_trig_mode[1]` selects the trigger source: 0 uses `trig_pin`, 1 uses `host_trig`. Activity on the unselected source starts no frame.
- R2: With `cfg_trig_sense`=1 the pin is active high, and with 0 it is active low. `trig_status` shows the sense-corrected pin level from the second clock edge after the pin changes, in either trigger mode.
- R3: Count the first clock edge after the selected trigger becomes active as cycle 1. `integ_active` is then high from cycle 3+max(`reg_trig_dly`*DIV_TRIG,1).
- R4: With `cfg_int_src` 00 or 11, `integ_active` stays high for max(`reg_int_time`*DIV_STEP,1) cycles.
- R5: With `cfg_int_src`=01, integration ends when the trigger goes inactive: `integ_active` is low from cycle 3 after that change. With `cfg_int_src`=10, `integ_active` is low after the clock edge that samples `sensor_int_end` high.
- R6: `readout_start` is a one-cycle pulse in the first cycle after `integ_active` falls.
- R7: When `reg_strb_adv` is nonzero, the strobe lights `reg_strb_adv`*DIV_ADV cycles before integration starts, and `reg_strb_dly` is ignored. This needs the trigger delay in cycles to exceed the advance in cycles.
- R8: When `reg_strb_adv` is zero, the strobe lights `reg_strb_dly`*DIV_SDLY cycles after integration starts. A value of zero lights it in the first integration cycle.
- R9: With `cfg_dur_en`=0 the strobe stays lit to the end of integration. With `cfg_dur_en`=1 it stays lit for min(`reg_strb_dur`*DIV_STEP, cycles left in integration), and a zero width never lights it. The strobe is never lit outside the delay and integration phases.
- R10: `cfg_strb_mode` sets the output: 00 gives a lit strobe as 1, 01 gives a lit strobe as 0, 10 holds the output at 1, and 11 holds it at 0. The two held settings ignore all triggers.
- R11: In one-shot mode (`cfg_trig_mode[0]`=0) each accepted edge gives exactly one frame. Trigger edges are ignored from acceptance until the sequencer is idle again after `readout_start`.
- R12: In retriggerable mode (`cfg_trig_mode[0]`=1), if the trigger is still active at readout, the next frame's integration starts 1+max(`reg_retrig_dly`*DIV_STEP,1)+max(`reg_trig_dly`*DIV_TRIG,1) cycles after the `readout_start` cycle. Frames stop once the trigger is inactive at readout or at the end of the gap.
- R13: During and right after reset, `integ_active` and `readout_start` are 0 and the strobe is unlit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_pin | input | 1 | External trigger pin |
| host_trig | input | 1 | Software trigger bit |
| cfg_trig_mode | input | 2 | [1] source select, [0] retriggerable |
| cfg_trig_sense | input | 1 | Pin polarity, 1 means active high |
| cfg_int_src | input | 2 | Integration length source |
| cfg_dur_en | input | 1 | Strobe width limit enable |
| cfg_strb_mode | input | 2 | Strobe polarity or held level |
| reg_trig_dly | input | 16 | Trigger delay, DIV_TRIG steps |
| reg_strb_adv | input | 8 | Strobe advance, DIV_ADV steps |
| reg_strb_dly | input | 16 | Strobe delay, DIV_SDLY steps |
| reg_strb_dur | input | 16 | Strobe width, DIV_STEP steps |
| reg_retrig_dly | input | 16 | Gap between repeated frames, DIV_STEP steps |
| reg_int_time | input | 16 | Integration time, DIV_STEP steps |
| sensor_int_end | input | 1 | Integration end pulse from the sensor side |
| integ_active | output | 1 | High while the sensor integrates |
| readout_start | output | 1 | One-cycle readout request |
| strobe | output | 1 | Illumination control |
| trig_status | output | 1 | Sense-corrected level of the pin |

## Verification
Each result is due a fixed number of cycles after its stimulus. Integration starts 3 plus the scaled trigger delay after a trigger change. An end of integration driven by the trigger shows 3 cycles after the release, and one driven by the sensor pulse shows 1 cycle after it. The readout pulse falls in the cycle where integration drops, and the strobe edges sit at fixed offsets from the integration edges. The bench stamps the clock-cycle number of every output edge at the falling clock edge and drives stimulus just after it. Expected stamps come from the drive cycle and the scaled register values, so each check compares exact cycle numbers and never waits on a window.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DELAY = 3'd1,
    PH_INTEG = 3'd2,
    PH_READ  = 3'd3,
    PH_GAP   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    LEN_REG    = 2'b00,
    LEN_WIDTH  = 2'b01,
    LEN_SENSOR = 2'b10,
    LEN_REG2   = 2'b11
  } len_src_e;

  typedef enum logic [1:0] {
    LIT_HIGH  = 2'b00,
    LIT_LOW   = 2'b01,
    HOLD_ONE  = 2'b10,
    HOLD_ZERO = 2'b11
  } lamp_mode_e;

endpackage

// File: rtl/trig_frontend.sv
module trig_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_pin,
  input  logic host_trig,
  input  logic sel_host,
  input  logic sense_high,
  output logic trig_act,
  output logic trig_edge,
  output logic pin_active
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] pin_sr;
  logic [SYNC_STAGES-1:0] host_sr;
  logic                   act_d;

  // both sources see the same number of stages so the latency matches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sr  <= '0;
      host_sr <= '0;
      act_d   <= 1'b1;  // a trigger must be seen inactive before it can start a frame
    end else begin
      pin_sr  <= {pin_sr[SYNC_STAGES-2:0], trig_pin};
      host_sr <= {host_sr[SYNC_STAGES-2:0], host_trig};
      act_d   <= trig_act;
    end
  end

  always_comb begin
    pin_active = sense_high ? pin_sr[LAST] : ~pin_sr[LAST];
    trig_act   = sel_host ? host_sr[LAST] : pin_active;
    trig_edge  = trig_act & ~act_d;
  end

endmodule

// File: rtl/seq_core.sv
module seq_core
  import trig_seq_pkg::*;
#(
  parameter int CW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_act,
  input  logic          trig_edge,
  input  logic          retrig_en,
  input  logic [1:0]    len_src,
  input  logic          sensor_int_end,
  input  logic [CW-1:0] dly_cyc,
  input  logic [CW-1:0] int_cyc,
  input  logic [CW-1:0] gap_cyc,
  output phase_e        ph_q,
  output logic [CW-1:0] cnt_q,
  output logic          integ_active,
  output logic          readout_start
);

  phase_e        ph_n;
  logic [CW-1:0] cnt_n;
  logic          last;

  assign last = (cnt_q <= CW'(1));

  always_comb begin
    ph_n  = ph_q;
    cnt_n = cnt_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (trig_edge) begin
          ph_n  = PH_DELAY;
          cnt_n = dly_cyc;
        end
      end
      PH_DELAY: begin
        if (last) begin
          ph_n  = PH_INTEG;
          cnt_n = int_cyc;
        end else begin
          cnt_n = cnt_q - CW'(1);
        end
      end
      PH_INTEG: begin
        case (len_src_e'(len_src))
          LEN_WIDTH:  if (!trig_act)      ph_n = PH_READ;
          LEN_SENSOR: if (sensor_int_end) ph_n = PH_READ;
          default: begin
            if (last) ph_n  = PH_READ;
            else      cnt_n = cnt_q - CW'(1);
          end
        endcase
      end
      PH_READ: begin
        if (retrig_en && trig_act) begin
          ph_n  = PH_GAP;
          cnt_n = gap_cyc;
        end else begin
          ph_n = PH_IDLE;
        end
      end
      PH_GAP: begin
        if (last) begin
          if (trig_act) begin
            ph_n  = PH_DELAY;
            cnt_n = dly_cyc;
          end else begin
            ph_n = PH_IDLE;
          end
        end else begin
          cnt_n = cnt_q - CW'(1);
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
    end
  end

  assign integ_active  = (ph_q == PH_INTEG);
  assign readout_start = (ph_q == PH_READ);

  // R6
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    readout_start |=> !readout_start);

  // R6
  rd_after_integ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(integ_active) |-> readout_start);

  // R11
  oneshot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readout_start && !retrig_en) |=> (ph_q == PH_IDLE));

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import trig_seq_pkg::*;
#(
  parameter int CW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        ph,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] adv_cyc,
  input  logic [CW-1:0] sdly_cyc,
  input  logic [CW-1:0] dur_cyc,
  input  logic          dur_en,
  input  logic [1:0]    lamp_mode,
  output logic          strobe
);

  logic [CW-1:0] elapsed;
  logic [CW-1:0] lit_cnt;
  logic          adv_on;
  logic          pre_win;
  logic          post_win;
  logic          lit;

  always_comb begin
    adv_on   = (adv_cyc != '0);
    pre_win  = (ph == PH_DELAY) && adv_on && (cnt_q <= adv_cyc);
    post_win = (ph == PH_INTEG) && (adv_on || (elapsed >= sdly_cyc));
    lit      = (pre_win || post_win) && (!dur_en || (lit_cnt < dur_cyc));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      lit_cnt <= '0;
    end else begin
      if (ph != PH_INTEG)      elapsed <= '0;
      else if (elapsed != '1)  elapsed <= elapsed + CW'(1);

      if (ph == PH_IDLE || ph == PH_READ || ph == PH_GAP) lit_cnt <= '0;
      else if (lit && lit_cnt != '1)                       lit_cnt <= lit_cnt + CW'(1);
    end
  end

  always_comb begin
    unique case (lamp_mode_e'(lamp_mode))
      LIT_HIGH:  strobe = lit;
      LIT_LOW:   strobe = ~lit;
      HOLD_ONE:  strobe = 1'b1;
      default:   strobe = 1'b0;
    endcase
  end

  // R9
  lit_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lit |-> (ph == PH_DELAY || ph == PH_INTEG));

  // R8
  no_adv_lit_integ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_on && lit) |-> (ph == PH_INTEG));

endmodule

// File: rtl/camera_trig_seq.sv
module camera_trig_seq
  import trig_seq_pkg::*;
#(
  parameter int DIV_TRIG    = 1000,
  parameter int DIV_ADV     = 250,
  parameter int DIV_SDLY    = 31,
  parameter int DIV_STEP    = 250,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig_pin,
  input  logic        host_trig,
  input  logic [1:0]  cfg_trig_mode,
  input  logic        cfg_trig_sense,
  input  logic [1:0]  cfg_int_src,
  input  logic        cfg_dur_en,
  input  logic [1:0]  cfg_strb_mode,
  input  logic [15:0] reg_trig_dly,
  input  logic [7:0]  reg_strb_adv,
  input  logic [15:0] reg_strb_dly,
  input  logic [15:0] reg_strb_dur,
  input  logic [15:0] reg_retrig_dly,
  input  logic [15:0] reg_int_time,
  input  logic        sensor_int_end,
  output logic        integ_active,
  output logic        readout_start,
  output logic        strobe,
  output logic        trig_status
);

  localparam int MAX_AB  = (DIV_TRIG > DIV_ADV) ? DIV_TRIG : DIV_ADV;
  localparam int MAX_CD  = (DIV_SDLY > DIV_STEP) ? DIV_SDLY : DIV_STEP;
  localparam int MAX_DIV = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW      = 16 + $clog2(MAX_DIV + 1);

  localparam logic [CW-1:0] K_TRIG = CW'(DIV_TRIG);
  localparam logic [CW-1:0] K_ADV  = CW'(DIV_ADV);
  localparam logic [CW-1:0] K_SDLY = CW'(DIV_SDLY);
  localparam logic [CW-1:0] K_STEP = CW'(DIV_STEP);

  logic          t_act;
  logic          t_edge;
  phase_e        ph;
  logic [CW-1:0] cnt;
  logic [CW-1:0] dly_cyc, int_cyc, gap_cyc, adv_cyc, sdly_cyc, dur_cyc;

  // register steps converted to clock cycles
  always_comb begin
    dly_cyc  = CW'(reg_trig_dly)   * K_TRIG;
    adv_cyc  = CW'(reg_strb_adv)   * K_ADV;
    sdly_cyc = CW'(reg_strb_dly)   * K_SDLY;
    dur_cyc  = CW'(reg_strb_dur)   * K_STEP;
    gap_cyc  = CW'(reg_retrig_dly) * K_STEP;
    int_cyc  = CW'(reg_int_time)   * K_STEP;
  end

  trig_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_pin   (trig_pin),
    .host_trig  (host_trig),
    .sel_host   (cfg_trig_mode[1]),
    .sense_high (cfg_trig_sense),
    .trig_act   (t_act),
    .trig_edge  (t_edge),
    .pin_active (trig_status)
  );

  seq_core #(.CW(CW)) u_core (
    .clk            (clk),
    .rst_n          (rst_n),
    .trig_act       (t_act),
    .trig_edge      (t_edge),
    .retrig_en      (cfg_trig_mode[0]),
    .len_src        (cfg_int_src),
    .sensor_int_end (sensor_int_end),
    .dly_cyc        (dly_cyc),
    .int_cyc        (int_cyc),
    .gap_cyc        (gap_cyc),
    .ph_q           (ph),
    .cnt_q          (cnt),
    .integ_active   (integ_active),
    .readout_start  (readout_start)
  );

  strobe_gen #(.CW(CW)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph),
    .cnt_q     (cnt),
    .adv_cyc   (adv_cyc),
    .sdly_cyc  (sdly_cyc),
    .dur_cyc   (dur_cyc),
    .dur_en    (cfg_dur_en),
    .lamp_mode (cfg_strb_mode),
    .strobe    (strobe)
  );

endmodule

// File: tb/test_camera_trig_seq.sv
module test_camera_trig_seq;

  localparam int CLK_PERIOD = 10;
  localparam int DT = 4;
  localparam int DA = 2;
  localparam int DD = 1;
  localparam int DS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_pin = 1'b0;
  logic        host_trig = 1'b0;
  logic [1:0]  cfg_trig_mode = 2'b00;
  logic        cfg_trig_sense = 1'b1;
  logic [1:0]  cfg_int_src = 2'b00;
  logic        cfg_dur_en = 1'b0;
  logic [1:0]  cfg_strb_mode = 2'b00;
  logic [15:0] reg_trig_dly = '0;
  logic [7:0]  reg_strb_adv = '0;
  logic [15:0] reg_strb_dly = '0;
  logic [15:0] reg_strb_dur = '0;
  logic [15:0] reg_retrig_dly = '0;
  logic [15:0] reg_int_time = '0;
  logic        sensor_int_end = 1'b0;
  logic        integ_active, readout_start, strobe, trig_status;

  camera_trig_seq #(
    .DIV_TRIG(DT), .DIV_ADV(DA), .DIV_SDLY(DD), .DIV_STEP(DS), .SYNC_STAGES(2)
  ) i_camera_trig_seq (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .host_trig(host_trig),
    .cfg_trig_mode(cfg_trig_mode), .cfg_trig_sense(cfg_trig_sense),
    .cfg_int_src(cfg_int_src), .cfg_dur_en(cfg_dur_en), .cfg_strb_mode(cfg_strb_mode),
    .reg_trig_dly(reg_trig_dly), .reg_strb_adv(reg_strb_adv), .reg_strb_dly(reg_strb_dly),
    .reg_strb_dur(reg_strb_dur), .reg_retrig_dly(reg_retrig_dly), .reg_int_time(reg_int_time),
    .sensor_int_end(sensor_int_end), .integ_active(integ_active),
    .readout_start(readout_start), .strobe(strobe), .trig_status(trig_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // event stamps taken at the falling edge
  int t_ion[8], t_ioff[8], t_rd[8], t_son[8], t_soff[8];
  int n_ion, n_ioff, n_rd, n_son, n_soff, n_s0, n_s1;
  bit integ_p, s_p, s_log;

  task automatic clr_mon();
    n_ion = 0; n_ioff = 0; n_rd = 0; n_son = 0; n_soff = 0; n_s0 = 0; n_s1 = 0;
    integ_p = 0; s_p = 0;
    for (int i = 0; i < 8; i++) begin
      t_ion[i] = -1; t_ioff[i] = -1; t_rd[i] = -1; t_son[i] = -1; t_soff[i] = -1;
    end
  endtask

  always @(negedge clk) begin
    s_log = (cfg_strb_mode == 2'b01) ? !strobe : strobe;
    if (strobe) n_s1++; else n_s0++;
    if (integ_active && !integ_p && n_ion < 8) begin t_ion[n_ion] = cyc; n_ion++; end
    if (!integ_active && integ_p && n_ioff < 8) begin t_ioff[n_ioff] = cyc; n_ioff++; end
    if (readout_start && n_rd < 8) begin t_rd[n_rd] = cyc; n_rd++; end
    if (s_log && !s_p && n_son < 8) begin t_son[n_son] = cyc; n_son++; end
    if (!s_log && s_p && n_soff < 8) begin t_soff[n_soff] = cyc; n_soff++; end
    integ_p = integ_active;
    s_p = s_log;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_rd(input int cnt);
    for (int k = 0; k < 4000 && n_rd < cnt; k++) step(1);
  endtask

  function automatic int mx1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // one-shot local frame, register integration length, pin held past readout
  task automatic do_frame(input int tdly, input int adv, input int sdly, input int dur,
                          input int itime, input bit den, input logic [1:0] smode);
    int n0, e_on, e_off, e_son, e_soff, uc;
    reg_trig_dly = 16'(tdly); reg_strb_adv = 8'(adv); reg_strb_dly = 16'(sdly);
    reg_strb_dur = 16'(dur); reg_int_time = 16'(itime); cfg_dur_en = den;
    cfg_strb_mode = smode; cfg_trig_mode = 2'b00; cfg_int_src = 2'b00;
    step(2); clr_mon(); step(1);
    n0 = cyc; trig_pin = 1'b1;
    wait_rd(1);
    step(20); trig_pin = 1'b0; step(6);
    e_on  = n0 + 3 + mx1(tdly * DT);
    e_off = e_on + mx1(itime * DS);
    chk("R3 integ start", t_ion[0], e_on);
    chk("R4 integ end", t_ioff[0], e_off);
    chk("R6 readout cycle", t_rd[0], e_off);
    chk("R11 one frame per edge", n_rd, 1);
    if (smode[1]) begin
      chk("R10 held level", smode[0] ? n_s1 : n_s0, 0);
    end else begin
      uc = dur * DS;
      e_son = (adv != 0) ? e_on - adv * DA : e_on + sdly * DD;
      if (den && uc == 0) begin
        chk("R9 zero width never lit", n_son, 0);
      end else begin
        e_soff = den ? mn(e_son + uc, e_off) : e_off;
        if (adv != 0) chk("R7 strobe advance", t_son[0], e_son);
        else          chk("R8 strobe delay", t_son[0], e_son);
        chk("R9 strobe end", t_soff[0], e_soff);
        chk("R10 polarity single pulse", n_son, 1);
      end
    end
  endtask

  initial begin
    int n0, k0, tc, ac, ic, tdly, adv, itime, sdly;
    void'($urandom(32'd4242));
    clr_mon();
    step(3);
    // R13 reset state
    chk("R13 integ in reset", integ_active, 0);
    chk("R13 readout in reset", readout_start, 0);
    chk("R13 strobe in reset", strobe, 0);
    rst_n = 1'b1;
    step(3);
    chk("R13 integ after reset", integ_active, 0);
    chk("R13 strobe after reset", strobe, 0);

    // R2 status latency and sense
    n0 = cyc; trig_pin = 1'b1;
    step(1); chk("R2 status not yet", trig_status, 0);
    step(1); chk("R2 status at cycle 2", trig_status, 1);
    trig_pin = 1'b0; step(40); clr_mon();

    // zero delay and zero time corner, then advance and delay directed frames
    do_frame(0, 0, 0, 0, 0, 1'b0, 2'b00);
    do_frame(5, 3, 7, 0, 4, 1'b0, 2'b00);   // R7: advance set, delay ignored
    do_frame(5, 0, 7, 0, 4, 1'b0, 2'b01);   // R8 with active-low output
    do_frame(5, 0, 2, 2, 6, 1'b1, 2'b00);   // R9 width shorter than integration
    do_frame(5, 4, 0, 9, 3, 1'b1, 2'b00);   // R9 width cut by end of integration
    do_frame(5, 0, 0, 0, 3, 1'b1, 2'b00);   // R9 zero width
    do_frame(3, 2, 0, 0, 2, 1'b0, 2'b10);   // R10 held one
    do_frame(3, 2, 0, 0, 2, 1'b0, 2'b11);   // R10 held zero

    // constrained random frames
    for (int r = 0; r < 10; r++) begin
      tdly  = 1 + int'($urandom % 20);
      tc    = tdly * DT;
      adv   = ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % ((tc - 1) / DA));
      itime = 1 + int'($urandom % 15);
      ic    = itime * DS;
      sdly  = int'($urandom % ic);
      do_frame(tdly, adv, sdly, int'($urandom % 16), itime, 1'($urandom % 2), 2'($urandom % 2));
    end

    // R11 edges during a running sequence are ignored
    reg_trig_dly = 10; reg_int_time = 10; reg_strb_adv = 0; cfg_dur_en = 0; cfg_strb_mode = 2'b00;
    step(2); clr_mon();
    n0 = cyc; trig_pin = 1'b1;
    step(5); trig_pin = 1'b0; step(4); trig_pin = 1'b1; step(4); trig_pin = 1'b0;
    step(50); trig_pin = 1'b1; step(4); trig_pin = 1'b0;
    wait_rd(1); step(30);
    chk("R11 mid-sequence edges ignored", n_rd, 1);
    chk("R11 start time unchanged", t_ion[0], n0 + 3 + 40);

    // R5 integration length from trigger width
    cfg_int_src = 2'b01; reg_trig_dly = 2;
    step(2); clr_mon();
    n0 = cyc; trig_pin = 1'b1;
    step(25); k0 = cyc; trig_pin = 1'b0;
    step(10);
    chk("R3 width mode start", t_ion[0], n0 + 3 + 8);
    chk("R5 width mode end", t_ioff[0], k0 + 3);
    chk("R6 width mode readout", t_rd[0], k0 + 3);

    // R5 integration length from sensor end pulse
    cfg_int_src = 2'b10;
    step(2); clr_mon();
    n0 = cyc; trig_pin = 1'b1;
    step(25); k0 = cyc; sensor_int_end = 1'b1;
    step(1); sensor_int_end = 1'b0;
    step(5); trig_pin = 1'b0; step(5);
    chk("R5 sensor mode end", t_ioff[0], k0 + 1);
    chk("R5 sensor mode single frame", n_rd, 1);

    // R1 host source, pin ignored
    cfg_int_src = 2'b00; reg_trig_dly = 3; reg_int_time = 2;
    cfg_trig_mode = 2'b10;
    step(4); clr_mon();
    n0 = cyc; host_trig = 1'b1;
    wait_rd(1); step(3); host_trig = 1'b0; step(5);
    chk("R1 host trigger start", t_ion[0], n0 + 3 + 12);
    clr_mon();
    n0 = cyc; trig_pin = 1'b1;
    step(2); chk("R2 status in host mode", trig_status, 1);
    step(40); trig_pin = 1'b0; step(5);
    chk("R1 pin ignored in host mode", n_ion, 0);

    // R2 active-low pin: change polarity while the host source is selected
    trig_pin = 1'b1; cfg_trig_sense = 1'b0;
    step(5); cfg_trig_mode = 2'b00;
    step(3); clr_mon();
    chk("R2 idle-high pin inactive", trig_status, 0);
    host_trig = 1'b1; step(40); host_trig = 1'b0; step(5);
    chk("R1 host bit ignored in local mode", n_ion, 0);
    n0 = cyc; trig_pin = 1'b0;
    wait_rd(1); step(3); trig_pin = 1'b1; step(5);
    chk("R2 falling edge starts frame", t_ion[0], n0 + 3 + 12);
    cfg_trig_mode = 2'b10; step(3);
    trig_pin = 1'b0; cfg_trig_sense = 1'b1; step(5);
    cfg_trig_mode = 2'b00; step(3);

    // R12 retriggerable: three frames, then stop
    reg_trig_dly = 2; reg_int_time = 3; reg_retrig_dly = 1;
    cfg_trig_mode = 2'b01;
    step(2); clr_mon();
    n0 = cyc; trig_pin = 1'b1;
    wait_rd(3); trig_pin = 1'b0;
    step(60);
    chk("R12 frame count", n_rd, 3);
    chk("R12 first start", t_ion[0], n0 + 3 + 8);
    chk("R12 second start", t_ion[1], t_rd[0] + 1 + 3 + 8);
    chk("R12 third start", t_ion[2], t_rd[1] + 1 + 3 + 8);
    chk("R4 repeated length", t_ioff[1] - t_ion[1], 9);
    cfg_trig_mode = 2'b00;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run hung (actual running, expected done)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule